// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a combinational logic array whose function is set by configuration registers. A set of product terms is shared by all outputs. Each product term is the AND of whichever input literals its configuration row enables, where a literal is an input in either its true or its complemented form. Each output is the OR of a group of product terms. A parameter chooses how that OR plane is built. In the programmable variant, each output has its own configuration column that picks which terms feed it. In the fixed-group variant, each output ORs a hard-wired set of terms, and only the AND plane can be configured.

Configuration is loaded through a synchronous write port. Each write carries a plane select, an address and a data word, and it rewrites one AND row or one OR column. The input and output buses are plain parallel vectors, and the path from `in_vec` to `out_vec` has no register in it. The default size is 3 inputs, 5 product terms and 4 outputs. That size is enough to build a two-input exclusive OR from two product terms.

Top module: `cfg_logic_array`

## Requirements
- R1: Reset, asynchronous and active low on `rst_n`, clears every configuration bit. While reset is held, and after it is released until the first write, `out_vec` is 0 for every input value.
- R2: A write with `cfg_sel`=0 loads AND row `cfg_addr`. Data bit 2i enables the true literal of `in_vec[i]`, and bit 2i+1 enables its complement. Bit 2·N_IN is the term enable; when it is 0 the term is 0. An enabled term is the AND of its enabled literals, so a term that enables both literals of one input is always 0.
- R3: An enabled product term with no literal enabled evaluates to 1.
- R4: In programmable mode (OR_PROG=1), a write with `cfg_sel`=1 loads OR column `cfg_addr`. Data bit t connects term t to that output, and each output is the OR of its connected terms. A later write to the same column replaces the earlier one.
- R5: An output with no enabled term connected reads 0.
- R6: In fixed-group mode (OR_PROG=0), output o is the OR of every term t for which t mod N_OUT = o. Writes with `cfg_sel`=1 have no effect on the outputs.
- R7: A configuration write changes the outputs only after the clock edge that samples it. A change on `in_vec` reaches `out_vec` in the same cycle, with no clock edge needed.
- R8: An AND write with `cfg_addr` ≥ N_TERM and an OR write with `cfg_addr` ≥ N_OUT change nothing.
- R9: With terms 0 and 4 set to `in_vec[0]`·¬`in_vec[1]` and ¬`in_vec[0]`·`in_vec[1]`, output 0 equals `in_vec[0]` XOR `in_vec[1]` in both modes. In programmable mode this needs column 0 = 5'b10001; in fixed-group mode term grouping gives it without any OR write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Plane select: 0 selects an AND row, 1 selects an OR column |
| cfg_addr | input | ADDR_W (3) | Row or column index |
| cfg_wdata | input | DATA_W (7) | Row literal/enable bits or column term bits |
| in_vec | input | N_IN (3) | Input variables |
| out_vec | output | N_OUT (4) | Output functions |

## Verification
Two things can happen in the same cycle: a configuration write is waiting for its clock edge while the combinational array is still being evaluated with the old configuration. The bench drives a write with the inputs held steady and samples the outputs at the falling edge before the capturing edge, where the old function must still be seen. It samples again at the falling edge after that rising edge, where the new function must be seen. A behavioural model applies each write at the same edge and is compared with both mode variants on every clock. This shows that no write leaks through early and that none is lost.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int MAX_LIT_IN = 32;
  localparam int MAX_TERMS  = 64;

  // Product of the literals enabled in a row; a row with no literal gives 1.
  function automatic logic lit_product(input logic [63:0] row,
                                       input logic [31:0] vin,
                                       input int n_in);
    logic r;
    r = 1'b1;
    for (int i = 0; i < MAX_LIT_IN; i++) begin
      if (i < n_in) begin
        if (row[2*i] && !vin[i])   r = 1'b0;
        if (row[2*i+1] && vin[i])  r = 1'b0;
      end
    end
    return r;
  endfunction

  // Fixed term group of output o: every term whose index is o modulo n_out.
  function automatic logic [63:0] fixed_group(input int o, input int n_term,
                                              input int n_out);
    logic [63:0] m;
    m = '0;
    for (int t = 0; t < MAX_TERMS; t++) begin
      if (t < n_term && (t % n_out) == o) m[t] = 1'b1;
    end
    return m;
  endfunction

  // OR of the terms selected by a mask; an empty mask gives 0.
  function automatic logic any_term(input logic [63:0] terms,
                                    input logic [63:0] mask);
    return |(terms & mask);
  endfunction

endpackage

// File: rtl/cla_and_plane.sv
module cla_and_plane #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int ADDR_W = 3,
  localparam int ROW_W = 2 * N_IN + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ROW_W-1:0]  wr_data,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_TERM-1:0] term_vec
);
  import cla_pkg::*;

  logic [ROW_W-1:0] rows [N_TERM];

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    logic row_hit;
    assign row_hit = wr_en && (wr_addr == ADDR_W'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rows[t] <= '0;
      else if (row_hit) rows[t] <= wr_data;
    end

    assign term_vec[t] = rows[t][ROW_W-1] &
                         lit_product(64'(rows[t][ROW_W-2:0]), 32'(in_vec), N_IN);
  end

endmodule

// File: rtl/cla_or_prog.sv
module cla_or_prog #(
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N_TERM-1:0] wr_data,
  input  logic [N_TERM-1:0] term_vec,
  output logic [N_OUT-1:0]  out_vec
);
  import cla_pkg::*;

  logic [N_TERM-1:0] cols [N_OUT];

  for (genvar o = 0; o < N_OUT; o++) begin : g_col
    logic col_hit;
    assign col_hit = wr_en && (wr_addr == ADDR_W'(o));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cols[o] <= '0;
      else if (col_hit) cols[o] <= wr_data;
    end

    assign out_vec[o] = any_term(64'(term_vec), 64'(cols[o]));
  end

endmodule

// File: rtl/cla_or_fixed.sv
module cla_or_fixed #(
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4
) (
  input  logic [N_TERM-1:0] term_vec,
  output logic [N_OUT-1:0]  out_vec
);
  import cla_pkg::*;

  for (genvar o = 0; o < N_OUT; o++) begin : g_grp
    localparam logic [N_TERM-1:0] GMASK = N_TERM'(fixed_group(o, N_TERM, N_OUT));
    assign out_vec[o] = any_term(64'(term_vec), 64'(GMASK));
  end

endmodule

// File: rtl/cfg_logic_array.sv
module cfg_logic_array #(
  parameter int N_IN    = 3,
  parameter int N_TERM  = 5,
  parameter int N_OUT   = 4,
  parameter bit OR_PROG = 1'b1,
  localparam int ROW_W  = 2 * N_IN + 1,
  localparam int DATA_W = (ROW_W > N_TERM) ? ROW_W : N_TERM,
  localparam int N_ADDR = (N_TERM > N_OUT) ? N_TERM : N_OUT,
  localparam int ADDR_W = (N_ADDR > 1) ? $clog2(N_ADDR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);

  // Named internal events, visible to the bound checker.
  logic              and_wr_hit;
  logic              or_wr_hit;
  logic [N_TERM-1:0] term_vec;

  assign and_wr_hit = cfg_we && !cfg_sel && (int'(cfg_addr) < N_TERM);
  assign or_wr_hit  = cfg_we &&  cfg_sel && (int'(cfg_addr) < N_OUT) && OR_PROG;

  cla_and_plane #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .ADDR_W (ADDR_W)
  ) u_and (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (and_wr_hit),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata[ROW_W-1:0]),
    .in_vec   (in_vec),
    .term_vec (term_vec)
  );

  if (OR_PROG) begin : g_pla
    cla_or_prog #(
      .N_TERM (N_TERM),
      .N_OUT  (N_OUT),
      .ADDR_W (ADDR_W)
    ) u_or (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (or_wr_hit),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata[N_TERM-1:0]),
      .term_vec (term_vec),
      .out_vec  (out_vec)
    );
  end else begin : g_pal
    cla_or_fixed #(
      .N_TERM (N_TERM),
      .N_OUT  (N_OUT)
    ) u_or (
      .term_vec (term_vec),
      .out_vec  (out_vec)
    );
  end

endmodule

// File: rtl/cla_checker.sv
module cla_checker #(
  parameter int N_IN    = 3,
  parameter int N_TERM  = 5,
  parameter int N_OUT   = 4,
  parameter bit OR_PROG = 1'b1,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [N_IN-1:0]   in_vec,
  input logic [N_OUT-1:0]  out_vec,
  input logic [N_TERM-1:0] term_vec,
  input logic              and_wr_hit,
  input logic              or_wr_hit
);
  import cla_pkg::*;

  localparam int ROW_W = 2 * N_IN + 1;
  localparam logic [ROW_W-1:0] ONLY_EN = {1'b1, {(ROW_W-1){1'b0}}};

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_vec == '0));

  assert_empty_row_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (and_wr_hit && cfg_wdata[ROW_W-1:0] == ONLY_EN)
    |=> |(term_vec & (N_TERM'(1) << $past(cfg_addr))));

  assert_no_term_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (term_vec == '0) |-> (out_vec == '0));

  assert_write_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(in_vec) && !$past(cfg_we)) |-> $stable(out_vec));

  assert_and_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && int'(cfg_addr) >= N_TERM)
    |=> (!$stable(in_vec) || $stable(term_vec)));

  if (!OR_PROG) begin : g_pal_chk
    assert_pal_no_colwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !or_wr_hit);
    for (genvar o = 0; o < N_OUT; o++) begin : g_o
      localparam logic [N_TERM-1:0] GM = N_TERM'(fixed_group(o, N_TERM, N_OUT));
      assert_pal_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vec[o] |-> |(term_vec & GM));
    end
  end

endmodule

bind cfg_logic_array cla_checker #(
  .N_IN    (N_IN),
  .N_TERM  (N_TERM),
  .N_OUT   (N_OUT),
  .OR_PROG (OR_PROG),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/sim_cfg_logic_array.sv
`timescale 1ns/1ps
module sim_cfg_logic_array;
  localparam int NI = 3, NT = 5, NO = 4, AW = 3, DW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [NI-1:0] in_vec = '0;
  logic [NO-1:0] out_pla, out_pal;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;

  // Reference configuration state.
  logic [6:0] m_and [NT];
  logic [4:0] m_or  [NO];

  always #10 clk = ~clk;

  cfg_logic_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO), .OR_PROG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_vec(in_vec), .out_vec(out_pla));

  cfg_logic_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO), .OR_PROG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_vec(in_vec), .out_vec(out_pal));

  function automatic bit m_term(int t, logic [NI-1:0] iv);
    if (m_and[t][6] == 1'b0) return 0;
    for (int i = 0; i < NI; i++) begin
      if (m_and[t][2*i] == 1'b1 && iv[i] == 1'b0) return 0;
      if (m_and[t][2*i+1] == 1'b1 && iv[i] == 1'b1) return 0;
    end
    return 1;
  endfunction

  function automatic logic [NO-1:0] m_out(bit fixed, logic [NI-1:0] iv);
    logic [NO-1:0] r = '0;
    for (int o = 0; o < NO; o++)
      for (int t = 0; t < NT; t++) begin
        bit conn = fixed ? ((t % NO) == o) : (m_or[o][t] == 1'b1);
        if (conn && m_term(t, iv)) r[o] = 1'b1;
      end
    return r;
  endfunction

  task automatic model_clear();
    for (int t = 0; t < NT; t++) m_and[t] = '0;
    for (int o = 0; o < NO; o++) m_or[o] = '0;
  endtask

  task automatic chk(string req, logic [NO-1:0] act, logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison of both variants with the model.
  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      chk("R4 cycle u0", out_pla, m_out(1'b0, in_vec));
      chk("R6 cycle u1", out_pal, m_out(1'b1, in_vec));
    end
  end

  task automatic cfg_write(bit sel, int addr, logic [DW-1:0] data);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = AW'(addr); cfg_wdata = data;
    @(posedge clk);
    if (!sel && addr < NT) m_and[addr] = data[6:0];
    if (sel && addr < NO) m_or[addr] = data[4:0];
    #2 cfg_we = 1'b0;
  endtask

  task automatic set_in(logic [NI-1:0] v);
    @(posedge clk); #2 in_vec = v;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    live = 1;

    // R1: cleared configuration gives 0 everywhere.
    for (int v = 0; v < 8; v++) begin
      set_in(NI'(v));
      chk("R1 u0", out_pla, 4'b0000);
      chk("R1 u1", out_pal, 4'b0000);
    end

    // R2: term 0 = in0 (bit0 true literal, bit6 enable).
    cfg_write(1'b0, 0, 7'b1000001);
    set_in(3'b001);
    chk("R5 u0 no column", out_pla, 4'b0000);
    chk("R2 R6 u1 term0 to out0", out_pal, 4'b0001);
    set_in(3'b000);
    chk("R2 u1 in0 low", out_pal, 4'b0000);

    // R7: column write is seen only after its capturing edge.
    set_in(3'b001);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_addr = 3'd0; cfg_wdata = 7'b0000001;
    @(negedge clk);
    chk("R7 before edge", out_pla, 4'b0000);
    @(posedge clk);
    m_or[0] = 5'b00001;
    #2 cfg_we = 1'b0;
    @(negedge clk);
    chk("R7 R4 after edge", out_pla, 4'b0001);
    #2 in_vec = 3'b000;
    #1 chk("R7 combinational path", out_pla, 4'b0000);

    // R2: complemented literal of in1 (bit3) on term 1, column 1.
    cfg_write(1'b0, 1, 7'b1001000);
    cfg_write(1'b1, 1, 7'b0000010);
    set_in(3'b000);
    chk("R2 compl u0", out_pla, 4'b0010);
    chk("R2 compl u1", out_pal, 4'b0010);
    set_in(3'b010);
    chk("R2 compl off u0", out_pla, 4'b0000);

    // R2: both literals of in2 on term 2 give 0.
    cfg_write(1'b0, 2, 7'b1110000);
    cfg_write(1'b1, 2, 7'b0000100);
    set_in(3'b100);
    chk("R2 contradiction hi", out_pla & 4'b0100, 4'b0000);
    set_in(3'b000);
    chk("R2 contradiction lo", out_pla & 4'b0100, 4'b0000);

    // R3: enabled term with no literal is 1.
    cfg_write(1'b0, 3, 7'b1000000);
    cfg_write(1'b1, 3, 7'b0001000);
    set_in(3'b101);
    chk("R3 u0 out3", out_pla & 4'b1000, 4'b1000);
    chk("R3 u1 out3", out_pal & 4'b1000, 4'b1000);

    // R4 overwrite, R6 column writes ignored in fixed mode.
    cfg_write(1'b1, 3, 7'b0000001);
    set_in(3'b000);
    chk("R4 overwrite u0 out3", out_pla & 4'b1000, 4'b0000);
    chk("R6 u1 ignores column", out_pal & 4'b1000, 4'b1000);

    // R8: out-of-range writes change nothing.
    cfg_write(1'b0, 5, 7'b1000000);
    cfg_write(1'b0, 7, 7'b1000000);
    cfg_write(1'b1, 4, 7'b0011111);
    cfg_write(1'b1, 6, 7'b0011111);
    set_in(3'b110);
    chk("R8 u0", out_pla, m_out(1'b0, 3'b110));
    chk("R8 u1", out_pal, m_out(1'b1, 3'b110));
    chk("R8 u0 fixed value", out_pla, 4'b0000);

    // R9: exclusive OR from terms 0 and 4.
    cfg_write(1'b0, 0, 7'b1001001);
    cfg_write(1'b0, 4, 7'b1000110);
    cfg_write(1'b1, 0, 7'b0010001);
    for (int v = 0; v < 4; v++) begin
      set_in(NI'(v));
      chk("R9 xor u0", out_pla & 4'b0001, {3'b000, 1'(v[0] ^ v[1])});
      chk("R9 xor u1", out_pal & 4'b0001, {3'b000, 1'(v[0] ^ v[1])});
    end

    // R1: reset in mid-run clears everything.
    @(posedge clk); #2 rst_n = 1'b0;
    model_clear();
    #2 chk("R1 held u0", out_pla, 4'b0000);
    chk("R1 held u1", out_pal, 4'b0000);
    @(posedge clk); #2 rst_n = 1'b1;
    for (int v = 0; v < 8; v += 3) begin
      set_in(NI'(v));
      chk("R1 after u0", out_pla, 4'b0000);
      chk("R1 after u1", out_pal, 4'b0000);
    end

    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule